// File: doc/BRIEF.md
# Sub-Band Energy Statistics Accumulator

This block measures how busy each of 42 wavelet sub-bands is over one video field. Each valid input sample brings a 16-bit signed transform coefficient and the index of the sub-band it belongs to. The block squares the coefficient and adds the result to a wide, saturating running total kept for that band. A rate-control processor later uses these per-band energies to choose new quantizer factors.

A single-cycle end-of-field pulse, given as vertical retrace begins, copies all running totals at once into a separate read bank and restarts the live totals from zero. The host can then read the frozen totals of one field while the next field is already accumulating. A ready flag tells the host that fresh totals are waiting. Reading the last band clears it. A second snapshot that arrives before that read raises an overrun flag.

The read side is a plain address/data register port. Address bit 0 selects the lower or upper half of a band's total, and the address bits above it select the band. Data appears one cycle after the read strobe.

Top module: `sbStatsAccum`

## Requirements
- R1: After reset, statsReady, statsOverrun and rdData are 0, and every band's banked total reads as 0.
- R2: In each cycle with sampleValid high and sampleBand below 42, the square of the signed 16-bit sampleData is added to that band's running total. A value of -32768 adds 2^30.
- R3: A sample with sampleValid low, or with sampleBand of 42 or more, changes no total.
- R4: A running total that would exceed 2^ACC_W-1 stays at 2^ACC_W-1 and does not wrap.
- R5: On a cycle with fieldEnd high, every band's running total is copied into the read bank, and the running totals restart from zero. A valid sample in that same cycle counts only toward the new field.
- R6: When rdEn is high, rdData in the next cycle holds a banked total selected by rdAddr. rdAddr bit 0 = 0 gives bits ACC_W/2-1..0 and bit 0 = 1 gives bits ACC_W-1..ACC_W/2. rdAddr bits above bit 0 give the band. A band of 42 or more returns 0. Without rdEn, rdData holds its value. A read in the snapshot cycle returns the previous bank.
- R7: statsReady goes high in the cycle after a fieldEnd. It goes low in the cycle after a read of band 41 (either half) that does not coincide with fieldEnd. If both happen in the same cycle, fieldEnd wins.
- R8: statsOverrun goes high after a fieldEnd that arrives while statsReady is high and band 41 is not being read in that cycle. It clears together with statsReady, and it is never high while statsReady is low.
- R9: Banked totals change only on fieldEnd, whatever sample traffic arrives between snapshots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe |
| sampleData | input | 16 | Signed transform coefficient |
| sampleBand | input | 6 | Sub-band index of the sample |
| fieldEnd | input | 1 | One-cycle end-of-field snapshot pulse |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 7 | {band, half select} |
| rdData | output | ACC_W/2 (24) | Selected half of a banked total |
| statsReady | output | 1 | Fresh totals waiting to be read |
| statsOverrun | output | 1 | A snapshot replaced totals that had not been read |

## Verification
A wrong running total stays hidden until the next fieldEnd moves it into the bank. After that, it appears on rdData one cycle after the host reads that band. The bench therefore reads the whole bank after every field, so that an error in any band or in either half shows up within about 85 cycles. Flag errors show on statsReady or statsOverrun in the cycle after the causing event, and the bench compares both flags on every clock. Saturation, ignored samples and the sample that coincides with a snapshot are each given their own field, so that an error there shows as a single wrong band value.

// File: rtl/sbStatsPkg.sv
package sbStatsPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accEn;     // sample is valid and addresses a real band
    logic snapshot;  // freeze totals into bank, restart accumulators
    logic rdStrobe;  // load read data register
  } dpCtrlT;
endpackage

// File: rtl/sbStatsCtrl.sv
module sbStatsCtrl
  import sbStatsPkg::*;
#(
  parameter int NUM_BANDS = 42,
  parameter int BAND_W    = 6,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [BAND_W-1:0] sampleBand,
  input  logic              fieldEnd,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output dpCtrlT            ctrl,
  output logic              statsReady,
  output logic              statsOverrun
);
  logic readLast;

  assign readLast = rdEn && (int'(rdAddr[ADDR_W-1:1]) == NUM_BANDS - 1);

  always_comb begin
    ctrl.accEn    = sampleValid && (int'(sampleBand) < NUM_BANDS);
    ctrl.snapshot = fieldEnd;
    ctrl.rdStrobe = rdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statsReady   <= 1'b0;
      statsOverrun <= 1'b0;
    end else if (fieldEnd) begin
      statsReady <= 1'b1;
      if (readLast)        statsOverrun <= 1'b0;
      else if (statsReady) statsOverrun <= 1'b1;
    end else if (readLast) begin
      statsReady   <= 1'b0;
      statsOverrun <= 1'b0;
    end
  end

  assert_ready_on_snap_R7: assert property (@(posedge clk) disable iff (!rstN)
    fieldEnd |=> statsReady);
  assert_ready_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (readLast && !fieldEnd) |=> !statsReady);
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fieldEnd && statsReady && !readLast) |=> statsOverrun);
  assert_overrun_implies_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    statsOverrun |-> statsReady);
endmodule

// File: rtl/sbStatsDatapath.sv
module sbStatsDatapath
  import sbStatsPkg::*;
#(
  parameter int NUM_BANDS = 42,
  parameter int SAMPLE_W  = 16,
  parameter int ACC_W     = 48,
  parameter int BAND_W    = 6,
  parameter int ADDR_W    = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrlT              ctrl,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [BAND_W-1:0]   sampleBand,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [ACC_W/2-1:0]  rdData
);
  localparam int HALF_W = ACC_W / 2;
  localparam int SQ_W   = 2 * SAMPLE_W;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;
  localparam logic [ACC_W-1:0] SQ_MAX  = ACC_W'(1) << (2 * SAMPLE_W - 2);

  logic signed [SQ_W-1:0] sqSigned;
  logic [ACC_W-1:0]       sqExt;
  logic [ACC_W-1:0]       acc  [NUM_BANDS];
  logic [ACC_W-1:0]       bank [NUM_BANDS];
  logic [BAND_W-1:0]      rdBand;

  always_comb begin
    sqSigned = SQ_W'($signed(sampleData)) * SQ_W'($signed(sampleData));
    sqExt    = ACC_W'($unsigned(sqSigned));
  end

  for (genvar i = 0; i < NUM_BANDS; i++) begin : gBand
    logic             hit;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] satSum;

    always_comb begin
      hit    = ctrl.accEn && (int'(sampleBand) == i);
      sum    = {1'b0, acc[i]} + {1'b0, sqExt};
      satSum = sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc[i]  <= '0;
        bank[i] <= '0;
      end else if (ctrl.snapshot) begin
        bank[i] <= acc[i];
        acc[i]  <= hit ? sqExt : '0;
      end else if (hit) begin
        acc[i]  <= satSum;
      end
    end

    assert_acc_monotonic_R2: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.snapshot |=> acc[i] >= $past(acc[i]));
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrl.snapshot && acc[i] == ACC_MAX) |=> acc[i] == ACC_MAX);
    assert_acc_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.snapshot |=> acc[i] <= SQ_MAX);
    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.snapshot |=> $stable(bank[i]));
  end

  assign rdBand = rdAddr[ADDR_W-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctrl.rdStrobe) begin
      if (int'(rdBand) < NUM_BANDS)
        rdData <= rdAddr[0] ? bank[rdBand][ACC_W-1:HALF_W] : bank[rdBand][HALF_W-1:0];
      else
        rdData <= '0;
    end
  end

  assert_bad_band_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rdStrobe && int'(rdBand) >= NUM_BANDS) |=> rdData == '0);
  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.rdStrobe |=> $stable(rdData));
endmodule

// File: rtl/sbStatsAccum.sv
module sbStatsAccum
  import sbStatsPkg::*;
#(
  parameter int NUM_BANDS = 42,
  parameter int SAMPLE_W  = 16,
  parameter int ACC_W     = 48,
  parameter int BAND_W    = $clog2(NUM_BANDS),
  parameter int ADDR_W    = BAND_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [BAND_W-1:0]   sampleBand,
  input  logic                fieldEnd,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [ACC_W/2-1:0]  rdData,
  output logic                statsReady,
  output logic                statsOverrun
);
  dpCtrlT ctrl;

  sbStatsCtrl #(.NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleBand(sampleBand),
    .fieldEnd(fieldEnd), .rdEn(rdEn), .rdAddr(rdAddr), .ctrl(ctrl),
    .statsReady(statsReady), .statsOverrun(statsOverrun));

  sbStatsDatapath #(.NUM_BANDS(NUM_BANDS), .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W),
                    .BAND_W(BAND_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sampleData(sampleData),
    .sampleBand(sampleBand), .rdAddr(rdAddr), .rdData(rdData));
endmodule

// File: tb/sbStatsAccum_tb.sv
module sbStatsAccum_tb_top;
  localparam int NB = 42;
  localparam int AW = 36;   // narrower totals so saturation is reachable
  localparam int HW = AW / 2;
  localparam longint MAXV = (64'sd1 <<< AW) - 1;
  localparam longint HMASK = (64'sd1 <<< HW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic [5:0] sampleBand = '0;
  logic fieldEnd = 1'b0;
  logic rdEn = 1'b0;
  logic [6:0] rdAddr = '0;
  logic [HW-1:0] rdData;
  logic statsReady, statsOverrun;

  always #2.5 clk = ~clk;   // 200 MHz

  sbStatsAccum #(.NUM_BANDS(NB), .ACC_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleBand(sampleBand), .fieldEnd(fieldEnd), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .statsReady(statsReady), .statsOverrun(statsOverrun));

  // behavioural reference model
  longint mAcc [NB];
  longint mBank[NB];
  longint mRd;
  bit mReady, mOver, lastRd;
  int b;
  longint sq, s;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mAcc[i]) begin mAcc[i] = 0; mBank[i] = 0; end
      mRd = 0; mReady = 0; mOver = 0;
    end else begin
      lastRd = rdEn && (int'(rdAddr >> 1) == NB - 1);
      if (rdEn) begin
        b = int'(rdAddr >> 1);
        if (b < NB) mRd = rdAddr[0] ? ((mBank[b] >> HW) & HMASK) : (mBank[b] & HMASK);
        else mRd = 0;
      end
      if (fieldEnd) begin
        if (lastRd) mOver = 0;
        else if (mReady) mOver = 1;
        mReady = 1;
        foreach (mAcc[i]) begin mBank[i] = mAcc[i]; mAcc[i] = 0; end
      end else if (lastRd) begin
        mReady = 0; mOver = 0;
      end
      if (sampleValid && int'(sampleBand) < NB) begin
        sq = longint'($signed(sampleData)) * longint'($signed(sampleData));
        s = mAcc[sampleBand] + sq;
        mAcc[sampleBand] = (s > MAXV) ? MAXV : s;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 0;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("rdData", longint'(rdData), mRd);
      chk("statsReady", longint'(statsReady), longint'(mReady));
      chk("statsOverrun", longint'(statsOverrun), longint'(mOver));
    end
  end

  task automatic cyc(bit v, logic [15:0] d, logic [5:0] bd, bit fe, bit re, logic [6:0] ra);
    sampleValid = v; sampleData = d; sampleBand = bd;
    fieldEnd = fe; rdEn = re; rdAddr = ra;
    @(negedge clk);
  endtask

  task automatic readAll();
    for (int a = 0; a < 2 * NB + 4; a++) cyc(0, 0, 0, 0, 1, 7'(a));
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    for (int a = 0; a < 2 * NB; a += 7) cyc(0, 0, 0, 0, 1, 7'(a));
    cyc(0, 0, 0, 0, 1, 7'(2 * NB - 1));   // band 41 read while not ready
    // random traffic in all bands, including extremes
    curReq = "R2";
    cyc(1, 16'h8000, 6'd0, 0, 0, 0);
    cyc(1, 16'h7fff, 6'd41, 0, 0, 0);
    cyc(1, 16'hffff, 6'd3, 0, 0, 0);
    for (int k = 0; k < 400; k++)
      cyc(1, 16'($urandom), 6'($urandom_range(0, NB - 1)), 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    curReq = "R6";
    readAll();
    // ignored samples
    curReq = "R3";
    cyc(1, 16'd1000, 6'd7, 0, 0, 0);
    for (int k = 0; k < 50; k++) cyc(1, 16'h8000, 6'($urandom_range(NB, 63)), 0, 0, 0);
    for (int k = 0; k < 50; k++) cyc(0, 16'h8000, 6'd9, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    readAll();
    // saturation: 70 x 2^30 exceeds 2^36-1
    curReq = "R4";
    for (int k = 0; k < 70; k++) cyc(1, 16'h8000, 6'd5, 0, 0, 0);
    cyc(1, 16'd3, 6'd6, 1, 0, 0);   // sample in snapshot cycle goes to new field
    readAll();
    curReq = "R5";
    cyc(0, 0, 0, 1, 0, 0);
    readAll();
    // overrun: two snapshots with no read of band 41
    curReq = "R8";
    cyc(1, 16'd200, 6'd2, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 7'd4);
    cyc(1, 16'd300, 6'd2, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 7'd4);
    cyc(0, 0, 0, 0, 1, 7'd83);   // clears ready and overrun
    cyc(0, 0, 0, 0, 0, 0);
    // read of band 41 coinciding with snapshot
    curReq = "R7";
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 7'd82);
    cyc(0, 0, 0, 0, 1, 7'd82);
    cyc(0, 0, 0, 1, 0, 0);
    // bank holds while the next field accumulates
    curReq = "R9";
    for (int k = 0; k < 2 * NB; k++)
      cyc(1, 16'($urandom), 6'(k % NB), 0, 1, 7'(k));
    cyc(0, 0, 0, 1, 0, 0);
    readAll();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule